// File: doc/BRIEF.md
# Processor Tick Timer

This block is a clocked tick timer for a processor core. It holds two words that software can read and write through a small register port. The first is a count word that goes up by one on each clock. The second is a control word that holds a two-bit operating mode, an interrupt enable, a sticky interrupt-pending flag and a 28-bit compare period. On every clock where the timer is live, the low 28 bits of the count are compared with the period. When they are equal, the pending flag can be raised, and the mode decides what the count does next.

There are four modes. Mode zero keeps the timer dormant. In restart mode the count drops to zero on a match and counts up again. In pause mode the count freezes at the matching value until software writes the count word. In free mode the count keeps running through the match. A small state machine tracks one thing: whether the timer is running or halted after a pause-mode match. The states are RUN and HALT. RUN goes to HALT on a pause-mode match. HALT goes back to RUN on any software write to the count word.

The level interrupt output is the pending flag gated by the timer-exception-enable input, which comes from the processor status word.

Top module: `tick_timer`

## Requirements
- R1: After reset the count word and the control word both read as zero, the interrupt output is low, and the state is RUN.
- R2: While the mode field (control bits 31:30) is 0, the count word holds its value and the pending flag (bit 28) is never set by hardware.
- R3: In RUN with a non-zero mode and no match, the count word increases by exactly one per clock and wraps from 0xFFFFFFFF to 0.
- R4: A match is the condition count[27:0] == control[27:0]; count bits 31:28 play no part. On a match in RUN with a non-zero mode, the pending flag is set at the next edge if the enable bit (bit 29) is 1, and left alone if the enable bit is 0.
- R5: Once set, the pending flag stays set until software writes the control word with bit 28 equal to 0. Writes to the count word do not clear it.
- R6: With mode 1 (restart), a match loads the count with zero at the next edge, and counting resumes from zero.
- R7: With mode 2 (pause), a match leaves the count at the matched value and enters HALT. In HALT the count holds and no match is evaluated, until software writes the count word.
- R8: With mode 3 (free), a match does not disturb counting: the count still increases by one.
- R9: irq_o is high exactly when the pending flag is 1 and tee_i is 1.
- R10: A software write takes effect over any hardware update of the same word in the same cycle. A write to the count word also returns the state machine to RUN.
- R11: reg_rdata shows the count word when reg_sel is 0 and the control word when reg_sel is 1, with no added latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Word select: 0 count, 1 control |
| reg_we | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| tee_i | input | 1 | Timer-exception enable from the status word |
| irq_o | output | 1 | Level timer interrupt |

## Verification
The bench targets several corner cases.

- **Pause mode.** A design that keeps counting past a pause match, or that never resumes after the count is rewritten, shows a wrong count on the next read.
- **Restart mode.** A design that loads one instead of zero, or skips the zero, produces a 0,1,2 sequence that is off by a step.
- **Same-cycle write.** Software writes the control word in the very cycle a match would set the pending flag. A design that lets hardware win leaves the flag set.
- **Wide count values.** Counts with the top bits set check the 28-bit compare, and a count near the 32-bit limit checks the wrap.
- **Random traffic.** Random register traffic is compared every cycle against a bench model, which catches a pending flag that clears itself or an interrupt that ignores tee_i.

// File: rtl/tick_pkg.sv
package tick_pkg;

    // Operating mode held in the two top bits of the control word
    typedef enum logic [1:0] {
        TM_OFF     = 2'd0,
        TM_RESTART = 2'd1,
        TM_PAUSE   = 2'd2,
        TM_FREE    = 2'd3
    } tt_mode_e;

    // Run/halt state of the counter
    typedef enum logic {
        TS_RUN  = 1'b0,
        TS_HALT = 1'b1
    } tt_state_e;

    // What the count register does in a cycle without a software write
    typedef enum logic [1:0] {
        CA_HOLD  = 2'd0,
        CA_INC   = 2'd1,
        CA_CLEAR = 2'd2
    } cnt_act_e;

    localparam logic SEL_CNT  = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

endpackage

// File: rtl/tick_match.sv
module tick_match #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned PER_W = 28
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [PER_W-1:0] period,
    output logic             hit
);
    // Only the low PER_W bits of the count take part in the compare
    assign hit = (cnt[PER_W-1:0] == period);
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
    import tick_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tt_mode_e  mode,
    input  logic      hit,
    input  logic      cnt_wr,
    output cnt_act_e  act,
    output logic      match_ev,
    output logic      halted
);
    tt_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_RUN: begin
                if (cnt_wr)
                    state_d = TS_RUN;
                else if (hit && (mode == TM_PAUSE))
                    state_d = TS_HALT;
            end
            TS_HALT: begin
                if (cnt_wr)
                    state_d = TS_RUN;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TS_RUN;
        else
            state_q <= state_d;
    end

    // Output decode
    always_comb begin
        act      = CA_HOLD;
        match_ev = 1'b0;
        if ((state_q == TS_RUN) && (mode != TM_OFF)) begin
            match_ev = hit;
            unique case (mode)
                TM_OFF:     act = CA_HOLD;
                TM_RESTART: act = hit ? CA_CLEAR : CA_INC;
                TM_PAUSE:   act = hit ? CA_HOLD  : CA_INC;
                TM_FREE:    act = CA_INC;
            endcase
        end
    end

    assign halted = (state_q == TS_HALT);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    input  cnt_act_e         act,
    input  logic             match_ev,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] ctrl_q
);
    localparam int unsigned IE_BIT = CNT_W - 3;
    localparam int unsigned IP_BIT = CNT_W - 4;

    // Count word: software write first, then the hardware action
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_cnt)
            cnt_q <= wdata;
        else begin
            unique case (act)
                CA_INC:   cnt_q <= cnt_q + CNT_W'(1);
                CA_CLEAR: cnt_q <= '0;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    // Control word: software write wins over the sticky pending set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= wdata;
        else if (match_ev && ctrl_q[IE_BIT])
            ctrl_q[IP_BIT] <= 1'b1;
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             tee_i,
    output logic             irq_o
);
    localparam int unsigned PER_W  = CNT_W - 4;
    localparam int unsigned IP_BIT = CNT_W - 4;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ctrl_q;
    logic             hit;
    logic             halted;
    logic             match_ev;
    logic             wr_cnt;
    logic             wr_ctrl;
    cnt_act_e         act;
    tt_mode_e         mode;

    assign wr_cnt  = reg_we && (reg_sel == SEL_CNT);
    assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
    assign mode    = tt_mode_e'(ctrl_q[CNT_W-1:CNT_W-2]);

    tick_match #(.CNT_W(CNT_W), .PER_W(PER_W)) u_match (
        .cnt    (cnt_q),
        .period (ctrl_q[PER_W-1:0]),
        .hit    (hit)
    );

    tick_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .hit      (hit),
        .cnt_wr   (wr_cnt),
        .act      (act),
        .match_ev (match_ev),
        .halted   (halted)
    );

    tick_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cnt   (wr_cnt),
        .wr_ctrl  (wr_ctrl),
        .wdata    (reg_wdata),
        .act      (act),
        .match_ev (match_ev),
        .cnt_q    (cnt_q),
        .ctrl_q   (ctrl_q)
    );

    assign reg_rdata = (reg_sel == SEL_CTRL) ? ctrl_q : cnt_q;
    assign irq_o     = ctrl_q[IP_BIT] & tee_i;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_sel,
    input logic             reg_we,
    input logic [CNT_W-1:0] reg_wdata,
    input logic             tee_i,
    input logic             irq_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] ctrl_q,
    input logic             hit,
    input logic             halted
);
    localparam int unsigned IP_BIT = CNT_W - 4;

    logic [1:0] md;
    assign md = ctrl_q[CNT_W-1:CNT_W-2];

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt_q == '0) && (ctrl_q == '0) && !halted);

    assert_off_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (md == 2'd0) && !reg_we |=> $stable(cnt_q));

    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (md != 2'd0) && !halted && !hit && !reg_we |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    assert_pending_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[IP_BIT] && !(reg_we && reg_sel) |=> ctrl_q[IP_BIT]);

    assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (md == 2'd1) && hit && !halted && !reg_we |=> cnt_q == '0);

    assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !(reg_we && !reg_sel) |=> halted && $stable(cnt_q));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> tee_i);

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && !reg_sel |=> (cnt_q == $past(reg_wdata)) && !halted);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .tee_i     (tee_i),
    .irq_o     (irq_o),
    .cnt_q     (cnt_q),
    .ctrl_q    (ctrl_q),
    .hit       (hit),
    .halted    (halted)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tee_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench model
    logic [31:0] m_cnt = '0, m_ctrl = '0;
    bit          m_stop = 0;
    logic [31:0] last_rd;
    logic        last_irq;
    logic        tee_v = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tee_i(tee_i), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic sel);
        return sel ? m_ctrl : m_cnt;
    endfunction

    function automatic logic exp_irq();
        return m_ctrl[28] & tee_v;
    endfunction

    // Advance the model by one clock
    task automatic model_step(input logic we, input logic sel, input logic [31:0] wd);
        logic [1:0]  md = m_ctrl[31:30];
        bit          hitv = (m_cnt[27:0] == m_ctrl[27:0]);
        logic [31:0] n_cnt = m_cnt;
        logic [31:0] n_ctrl = m_ctrl;
        bit          n_stop = m_stop;
        if (!m_stop && md != 2'd0) begin
            if (hitv && m_ctrl[29]) n_ctrl[28] = 1'b1;
            case (md)
                2'd1: n_cnt = hitv ? 32'd0 : m_cnt + 1;
                2'd2: if (hitv) n_stop = 1; else n_cnt = m_cnt + 1;
                default: n_cnt = m_cnt + 1;
            endcase
        end
        if (we && !sel) begin n_cnt = wd; n_stop = 0; end
        if (we && sel) n_ctrl = wd;
        m_cnt = n_cnt; m_ctrl = n_ctrl; m_stop = n_stop;
    endtask

    // One cycle: drive, compare outputs with model, clock, update model
    task automatic cyc(input logic we, input logic sel, input logic [31:0] wd);
        @(negedge clk);
        reg_we = we; reg_sel = sel; reg_wdata = wd; tee_i = tee_v;
        #1;
        last_rd = reg_rdata; last_irq = irq_o;
        check(sel ? "R5 control read" : "R3 count read", last_rd, exp_read(sel));
        check("R9 irq", {31'd0, last_irq}, {31'd0, exp_irq()});
        @(posedge clk);
        model_step(we, sel, wd);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        cyc(0, 0, 0); check("R1 count", last_rd, 32'h0);
        cyc(0, 1, 0); check("R1 control", last_rd, 32'h0);
        check("R1 irq", {31'd0, last_irq}, 32'd0);

        // R2 dormant mode holds
        cyc(1, 0, 32'd5);
        cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
        check("R2 count held", last_rd, 32'd5);

        // R11 read mux of control word
        cyc(1, 1, 32'h2000_0007);
        cyc(0, 1, 0); check("R11 control readback", last_rd, 32'h2000_0007);
        cyc(1, 1, 32'h0);

        // R6 restart mode, period 2, enable set
        cyc(1, 0, 32'd0);
        cyc(1, 1, 32'h6000_0002);
        for (int i = 0; i < 6; i++) begin
            cyc(0, 0, 0);
            check("R6 restart sequence", last_rd, 32'(i % 3));
        end
        cyc(0, 1, 0); check("R4 pending set on match", last_rd, 32'h7000_0002);

        // R5 pending survives a count write, cleared by control write
        cyc(1, 0, 32'd1);
        cyc(0, 1, 0); check("R5 pending kept", last_rd, 32'h7000_0002);
        cyc(1, 1, 32'h4000_0002);
        for (int i = 0; i < 4; i++) begin
            cyc(0, 1, 0);
            check("R4 enable clear, no pending", last_rd, 32'h4000_0002);
        end

        // R9 interrupt gating
        cyc(1, 1, 32'h7000_0002);
        tee_v = 1'b0; cyc(0, 1, 0);
        check("R9 irq low with tee low", {31'd0, last_irq}, 32'd0);
        tee_v = 1'b1; cyc(0, 1, 0);
        check("R9 irq high", {31'd0, last_irq}, 32'd1);
        cyc(1, 1, 32'h0);
        tee_v = 1'b0;

        // R7 pause mode, period 3
        cyc(1, 0, 32'd0);
        cyc(1, 1, 32'h8000_0003);
        for (int i = 0; i < 7; i++) begin
            cyc(0, 0, 0);
            check("R7 pause sequence", last_rd, (i < 3) ? 32'(i) : 32'd3);
        end
        cyc(1, 0, 32'd10);
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 0);
            check("R10 resume after count write", last_rd, 32'(10 + i));
        end
        cyc(1, 1, 32'h0);

        // R8 free mode past a match, R3 wrap
        cyc(1, 0, 32'hFFFF_FFFE);
        cyc(1, 1, 32'hC000_0000);
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 0);
            check("R8 R3 free-run wrap", last_rd, 32'hFFFF_FFFE + 32'(i));
        end

        // R4 upper count bits ignored in the compare
        cyc(1, 1, 32'h0);
        cyc(1, 0, 32'h1000_0003);
        cyc(1, 1, 32'hE000_0003);
        cyc(0, 0, 0); check("R4 count with top bits", last_rd, 32'h1000_0003);
        cyc(0, 1, 0); check("R4 match on low bits", last_rd, 32'hF000_0003);

        // R10 control write beats pending set in the match cycle
        cyc(1, 1, 32'h0);
        cyc(1, 0, 32'd0);
        cyc(1, 1, 32'hE000_0005);
        cyc(1, 0, 32'd5);
        cyc(1, 1, 32'hE000_0005);
        cyc(0, 1, 0); check("R10 write wins over pending", last_rd, 32'hE000_0005);

        // Random traffic, checked every cycle against the model
        for (int n = 0; n < 4000; n++) begin
            logic        we  = ($urandom % 8) == 0;
            logic        sel = $urandom % 2;
            logic [31:0] wd;
            if ($urandom % 16 == 0) tee_v = $urandom % 2;
            if (sel)
                wd = {2'($urandom), 2'($urandom), 28'($urandom % 24)};
            else case ($urandom % 4)
                0: wd = 32'hFFFF_FFF0 + 32'($urandom % 16);
                1: wd = {4'($urandom), 28'($urandom % 24)};
                default: wd = 32'($urandom % 24);
            endcase
            cyc(we, sel, wd);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule